// File: doc/BRIEF.md
# Hardwired Parallel Subscription Matcher

This block matches a stream of events against a fixed set of subscriptions. An event is a group of unsigned attribute values. A subscription is a conjunction of predicates. Each predicate compares one attribute with either a constant or another attribute of the same event. Every subscription is fixed at elaboration time through a table parameter and becomes its own comparator unit, so no memory is read during matching. All units look at the same event in the same cycle, and the per-subscription hits are registered together as one bitmap.

After the match cycle, a pipelined adder tree counts the hits while the bitmap travels beside it. The count and the bitmap leave together through a valid/ready output. A small driver produces one common advance enable, so the comparator stage, the tree and the valid pipeline move in lockstep. One event can be accepted per clock. When the consumer holds off, the whole pipeline freezes and the input side stops accepting.

Top module: `subm_matcher`

## Requirements
- R1: Bit s of the result bitmap is 1 exactly when every one of the first NPRED predicates of subscription s holds for the accepted event. A predicate reads table entry s*4+p. It compares attribute `lhs`, taken from bits lhs*AW upward of `ev_attrs`, as an unsigned value. The other operand is either attribute `rhs_idx`, when `rhs_is_attr` is 1, or the low AW bits of `value`.
- R2: Operator codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than and 5 greater or equal, with the attribute on the left. Code 6 is never true and code 7 is always true.
- R3: `res_count` equals the number of ones in `res_hits` whenever `res_valid` is high, and it never exceeds NSUB.
- R4: With `res_ready` held high, the result of an event accepted at a clock edge becomes visible clog2(NSUB)+1 edges later, counting that accepting edge.
- R5: With `res_ready` high, an event is accepted on every cycle that `ev_valid` is high. Results come out in acceptance order, none lost or duplicated.
- R6: While `res_ready` is low, `ev_ready` is low, and a presented result keeps `res_valid`, `res_count` and `res_hits` unchanged until it is taken.
- R7: While `rst_n` is low, and in the first cycle after it is released, `res_valid` is 0.
- R8: Each result carries the bitmap of its own event, with bit s belonging to subscription s and no mixing between neighbouring events in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event will be taken at the next edge |
| ev_attrs | input | NATTR*AW | Packed attribute values, attribute i in bits i*AW upward |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer accepts the result; also the pipeline advance |
| res_count | output | clog2(NSUB+1) | Number of matching subscriptions |
| res_hits | output | NSUB | Per-subscription match bitmap |

## Verification
The assertions assume the consumer takes a result only through `res_ready`, and that `ev_attrs` is sampled only when `ev_valid` and `ev_ready` are both high. The bench changes inputs only between edges, and it lets attribute values change freely while nothing is being accepted. The hold and handshake properties rely on a table whose attribute indices all fall below NATTR, and elaboration rejects any table that breaks this. The bench sweeps every event of a three-attribute, three-bit configuration twice: once back to back, and once with regular stalls and input gaps.

// File: rtl/subm_pkg.sv
package subm_pkg;

   localparam int MAX_SUB  = 16;
   localparam int MAX_PRED = 4;
   localparam int IDX_W    = 4;
   localparam int VAL_W    = 16;

   typedef enum logic [2:0] {
      OP_EQ     = 3'd0,
      OP_NE     = 3'd1,
      OP_LT     = 3'd2,
      OP_LE     = 3'd3,
      OP_GT     = 3'd4,
      OP_GE     = 3'd5,
      OP_NEVER  = 3'd6,
      OP_ALWAYS = 3'd7
   } pred_op_e;

   typedef struct packed {
      pred_op_e           op;
      logic               rhs_is_attr;
      logic [IDX_W-1:0]   lhs;
      logic [IDX_W-1:0]   rhs_idx;
      logic [VAL_W-1:0]   value;
   } pred_t;

   typedef pred_t [MAX_SUB*MAX_PRED-1:0] sub_table_t;

   // Default table: one real predicate per subscription, the rest always true.
   function automatic sub_table_t default_table();
      sub_table_t t;
      for (int s = 0; s < MAX_SUB; s++) begin
         for (int p = 0; p < MAX_PRED; p++) begin
            t[s*MAX_PRED+p].op          = (p == 0) ? pred_op_e'(s % 6) : OP_ALWAYS;
            t[s*MAX_PRED+p].rhs_is_attr = (s % 2 == 1);
            t[s*MAX_PRED+p].lhs         = IDX_W'(s % 4);
            t[s*MAX_PRED+p].rhs_idx     = IDX_W'((s + 1) % 4);
            t[s*MAX_PRED+p].value       = VAL_W'(s * 7);
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/subm_pred.sv
module subm_pred #(
   parameter int             AW    = 8,
   parameter int             NATTR = 4,
   parameter subm_pkg::pred_t P    = '0
) (
   input  logic [NATTR*AW-1:0] attrs,
   output logic                ok
);
   localparam int LI = int'(P.lhs);
   localparam int RI = int'(P.rhs_idx);

   logic [AW-1:0] a_val;
   logic [AW-1:0] b_val;
   logic          unused_attrs;

   assign unused_attrs = ^attrs;
   assign a_val        = attrs[LI*AW +: AW];

   generate
      if (P.rhs_is_attr) begin : g_rhs_attr
         assign b_val = attrs[RI*AW +: AW];
      end else begin : g_rhs_const
         assign b_val = P.value[AW-1:0];
      end
   endgenerate

   always_comb begin
      case (P.op)
         subm_pkg::OP_EQ:     ok = (a_val == b_val);
         subm_pkg::OP_NE:     ok = (a_val != b_val);
         subm_pkg::OP_LT:     ok = (a_val <  b_val);
         subm_pkg::OP_LE:     ok = (a_val <= b_val);
         subm_pkg::OP_GT:     ok = (a_val >  b_val);
         subm_pkg::OP_GE:     ok = (a_val >= b_val);
         subm_pkg::OP_NEVER:  ok = 1'b0;
         default:             ok = 1'b1;
      endcase
   end
endmodule

// File: rtl/subm_sub.sv
module subm_sub #(
   parameter int                   AW    = 8,
   parameter int                   NATTR = 4,
   parameter int                   NPRED = 4,
   parameter int                   SIDX  = 0,
   parameter subm_pkg::sub_table_t TBL   = subm_pkg::default_table()
) (
   input  logic [NATTR*AW-1:0] attrs,
   output logic                hit
);
   logic [NPRED-1:0] term;

   generate
      for (genvar p = 0; p < NPRED; p++) begin : g_term
         localparam subm_pkg::pred_t PP = TBL[SIDX*subm_pkg::MAX_PRED + p];
         if (int'(PP.lhs) >= NATTR) begin : g_bad_lhs
            $error("subm_sub: left attribute index out of range");
         end
         if (PP.rhs_is_attr && int'(PP.rhs_idx) >= NATTR) begin : g_bad_rhs
            $error("subm_sub: right attribute index out of range");
         end
         subm_pred #(
            .AW    (AW),
            .NATTR (NATTR),
            .P     (PP)
         ) pred_i (
            .attrs (attrs),
            .ok    (term[p])
         );
      end
   endgenerate

   assign hit = &term;
endmodule

// File: rtl/subm_driver.sv
module subm_driver #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_valid,
   input  logic res_ready,
   output logic ev_ready,
   output logic adv,
   output logic res_valid
);
   logic [DEPTH-1:0] vld_q;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("subm_driver: depth must be at least 2");
      end
   endgenerate

   assign adv      = res_ready;
   assign ev_ready = res_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (adv) begin
         vld_q <= {vld_q[DEPTH-2:0], ev_valid};
      end
   end

   assign res_valid = vld_q[DEPTH-1];
endmodule

// File: rtl/subm_tally.sv
module subm_tally #(
   parameter int NSUB = 16,
   parameter int LVL  = 4,
   parameter int CW   = 5
) (
   input  logic            clk,
   input  logic            adv,
   input  logic [NSUB-1:0] hits_in,
   output logic [CW-1:0]   count,
   output logic [NSUB-1:0] hits_out
);
   localparam int NPAD = 1 << LVL;

   logic [NPAD-1:0] hits_pad;
   assign hits_pad = NPAD'(hits_in);

   generate
      for (genvar k = 0; k <= LVL; k++) begin : g_lvl
         logic [CW-1:0] sum [NPAD >> k];
         if (k == 0) begin : g_leaf
            always_comb begin
               for (int j = 0; j < NPAD; j++) begin
                  sum[j] = CW'(hits_pad[j]);
               end
            end
         end else begin : g_node
            always_ff @(posedge clk) begin
               if (adv) begin
                  for (int j = 0; j < (NPAD >> k); j++) begin
                     sum[j] <= g_lvl[k-1].sum[2*j] + g_lvl[k-1].sum[2*j+1];
                  end
               end
            end
         end
      end
   endgenerate

   assign count = g_lvl[LVL].sum[0];

   logic [NSUB-1:0] bm_q [LVL];

   always_ff @(posedge clk) begin
      if (adv) begin
         bm_q[0] <= hits_in;
         for (int i = 1; i < LVL; i++) begin
            bm_q[i] <= bm_q[i-1];
         end
      end
   end

   assign hits_out = bm_q[LVL-1];
endmodule

// File: rtl/subm_matcher.sv
module subm_matcher #(
   parameter int                   NSUB  = 16,
   parameter int                   NPRED = 4,
   parameter int                   NATTR = 4,
   parameter int                   AW    = 8,
   parameter subm_pkg::sub_table_t SUBS  = subm_pkg::default_table(),
   localparam int                  LVL   = $clog2(NSUB),
   localparam int                  CW    = $clog2(NSUB + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_valid,
   output logic                ev_ready,
   input  logic [NATTR*AW-1:0] ev_attrs,
   output logic                res_valid,
   input  logic                res_ready,
   output logic [CW-1:0]       res_count,
   output logic [NSUB-1:0]     res_hits
);
   generate
      if (NSUB < 2 || NSUB > subm_pkg::MAX_SUB) begin : g_bad_nsub
         $error("subm_matcher: NSUB out of range");
      end
      if (NPRED < 1 || NPRED > subm_pkg::MAX_PRED) begin : g_bad_npred
         $error("subm_matcher: NPRED out of range");
      end
      if (NATTR < 1 || NATTR > (1 << subm_pkg::IDX_W)) begin : g_bad_nattr
         $error("subm_matcher: NATTR out of range");
      end
      if (AW < 1 || AW > subm_pkg::VAL_W) begin : g_bad_aw
         $error("subm_matcher: AW out of range");
      end
   endgenerate

   logic adv;

   subm_driver #(
      .DEPTH (LVL + 1)
   ) drv_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .res_ready (res_ready),
      .ev_ready  (ev_ready),
      .adv       (adv),
      .res_valid (res_valid)
   );

   logic [NSUB-1:0] hit_now;
   logic [NSUB-1:0] hit_q;

   generate
      for (genvar s = 0; s < NSUB; s++) begin : g_unit
         subm_sub #(
            .AW    (AW),
            .NATTR (NATTR),
            .NPRED (NPRED),
            .SIDX  (s),
            .TBL   (SUBS)
         ) unit_i (
            .attrs (ev_attrs),
            .hit   (hit_now[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (adv) begin
         hit_q <= hit_now;
      end
   end

   subm_tally #(
      .NSUB (NSUB),
      .LVL  (LVL),
      .CW   (CW)
   ) tally_i (
      .clk      (clk),
      .adv      (adv),
      .hits_in  (hit_q),
      .count    (res_count),
      .hits_out (res_hits)
   );

   // R3: tree sum agrees with the bitmap carried beside it
   a_r3_count_popcount: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_count == CW'($countones(res_hits))));

   // R3: count never exceeds the number of subscriptions
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_count <= CW'(NSUB)));

   // R6: a stalled result stays put
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_count) && $stable(res_hits)));

   // R6: nothing enters while the output is blocked
   a_r6_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_ready && !res_valid) |=> !res_valid);

   // R4: a result appears only after an advancing cycle
   a_r4_valid_after_advance: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(adv));
endmodule

// File: tb/subm_matcher_tb_top.sv
module subm_matcher_tb_top;
   import subm_pkg::*;

   localparam int NSUB  = 8;
   localparam int NPRED = 3;
   localparam int NATTR = 3;
   localparam int AW    = 3;
   localparam int CW    = 4;
   localparam int LAT   = 4;

   function automatic pred_t mk(pred_op_e op, int l, int isattr, int r, int v);
      pred_t x;
      x.op          = op;
      x.lhs         = IDX_W'(l);
      x.rhs_is_attr = (isattr != 0);
      x.rhs_idx     = IDX_W'(r);
      x.value       = VAL_W'(v);
      return x;
   endfunction

   function automatic sub_table_t build();
      sub_table_t t;
      for (int i = 0; i < MAX_SUB*MAX_PRED; i++) t[i] = mk(OP_ALWAYS, 0, 0, 0, 0);
      t[0*4+0] = mk(OP_EQ, 0, 0, 0, 5);
      t[1*4+0] = mk(OP_LT, 0, 1, 1, 0);
      t[1*4+1] = mk(OP_NE, 2, 0, 0, 0);
      t[2*4+0] = mk(OP_GE, 2, 0, 0, 4);
      t[2*4+1] = mk(OP_LE, 0, 0, 0, 2);
      t[2*4+2] = mk(OP_GT, 1, 0, 0, 1);
      t[3*4+0] = mk(OP_EQ, 1, 1, 2, 0);
      t[5*4+1] = mk(OP_NEVER, 0, 0, 0, 0);
      t[6*4+0] = mk(OP_GE, 0, 1, 2, 0);
      t[6*4+1] = mk(OP_LE, 1, 1, 0, 0);
      t[7*4+0] = mk(OP_NE, 1, 0, 0, 3);
      t[7*4+1] = mk(OP_LT, 2, 0, 0, 6);
      t[7*4+2] = mk(OP_GT, 0, 0, 0, 8'd9);  // constant truncates to 1
      return t;
   endfunction

   localparam sub_table_t TBL = build();

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                ev_valid = 1'b0;
   logic                ev_ready;
   logic [NATTR*AW-1:0] ev_attrs = '0;
   logic                res_valid;
   logic                res_ready = 1'b1;
   logic [CW-1:0]       res_count;
   logic [NSUB-1:0]     res_hits;

   always #2 clk = ~clk;

   subm_matcher #(
      .NSUB  (NSUB),
      .NPRED (NPRED),
      .NATTR (NATTR),
      .AW    (AW),
      .SUBS  (TBL)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_ready  (ev_ready),
      .ev_attrs  (ev_attrs),
      .res_valid (res_valid),
      .res_ready (res_ready),
      .res_count (res_count),
      .res_hits  (res_hits)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference model (R1, R2): arithmetic evaluation of each predicate
   function automatic int fld(int ev, int idx);
      return (ev >> (idx*AW)) % (1 << AW);
   endfunction

   function automatic int ref_hits(int ev);
      int bm = 0;
      for (int s = 0; s < NSUB; s++) begin
         bit all = 1;
         for (int p = 0; p < NPRED; p++) begin
            pred_t e = TBL[s*MAX_PRED+p];
            int a = fld(ev, int'(e.lhs));
            int b = e.rhs_is_attr ? fld(ev, int'(e.rhs_idx)) : int'(e.value) % (1 << AW);
            bit r;
            case (int'(e.op))
               0: r = (a == b);
               1: r = (a != b);
               2: r = (a <  b);
               3: r = (a <= b);
               4: r = (a >  b);
               5: r = (a >= b);
               6: r = 0;
               default: r = 1;
            endcase
            all = all & r;
         end
         if (all) bm = bm | (1 << s);
      end
      return bm;
   endfunction

   function automatic int ones(int v);
      int c = 0;
      for (int i = 0; i < NSUB; i++) c += (v >> i) & 1;
      return c;
   endfunction

   int expq[$];
   bit was_stalled = 0;
   int held_cnt = 0;
   int held_hits = 0;

   task automatic step(input bit v, input int ev, input bit rdy);
      @(negedge clk);
      ev_valid  = v;
      ev_attrs  = (NATTR*AW)'(ev);
      res_ready = rdy;
      #1;
      if (was_stalled) begin
         chk(res_valid == 1'b1, "R6 result dropped while stalled", int'(res_valid), 1);
         chk(int'(res_count) == held_cnt, "R6 count changed while stalled", int'(res_count), held_cnt);
         chk(int'(res_hits) == held_hits, "R6 bitmap changed while stalled", int'(res_hits), held_hits);
      end
      if (!rdy) chk(ev_ready == 1'b0, "R6 ev_ready high during stall", int'(ev_ready), 0);
      else      chk(ev_ready == 1'b1, "R5 ev_ready low with output ready", int'(ev_ready), 1);
      if (res_valid && res_ready) begin
         int e;
         if (expq.size() == 0) begin
            chk(0, "R5 unexpected result", int'(res_hits), -1);
         end else begin
            e = expq.pop_front();
            chk(int'(res_hits) == e, "R1/R8 bitmap", int'(res_hits), e);
            chk(int'(res_count) == ones(e), "R3 count", int'(res_count), ones(e));
         end
      end
      if (ev_valid && ev_ready) expq.push_back(ref_hits(ev));
      was_stalled = res_valid && !res_ready;
      held_cnt    = int'(res_count);
      held_hits   = int'(res_hits);
   endtask

   initial begin
      int lat;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 chk(res_valid == 1'b0, "R7 valid during reset", int'(res_valid), 0);
      ev_valid = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      ev_valid = 1'b0;
      #1 chk(res_valid == 1'b0, "R7 valid after reset", int'(res_valid), 0);

      // R4: latency of a single event
      step(1, 9'o257, 1);
      lat = 0;
      for (int k = 1; k <= 10; k++) begin
         step(0, 0, 1);
         if (res_valid && lat == 0) lat = k;
      end
      chk(lat == LAT, "R4 latency", lat, LAT);

      // R1 R2 R3 R5 R8: exhaustive sweep, back to back
      for (int ev = 0; ev < (1 << (NATTR*AW)); ev++) step(1, ev, 1);
      for (int k = 0; k < 8; k++) step(0, 0, 1);
      chk(expq.size() == 0, "R5 results lost in sweep", expq.size(), 0);

      // R6: sweep in reverse with stalls and input gaps
      for (int c = 0, ev = (1 << (NATTR*AW)) - 1; ev >= 0; c++) begin
         bit v = (c % 7) != 2;
         bit r = (c % 5) != 3 && (c % 11) != 6;
         step(v, ev, r);
         if (v && r) ev--;
      end
      for (int k = 0; k < 8; k++) step(0, 0, 1);
      chk(expq.size() == 0, "R5 results lost with stalls", expq.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule